// File: doc/BRIEF.md
# Performance Monitor Counter Bank

A bank of six 32-bit event counters for a processor core. Each clock the core reports how many instructions it completed in that cycle, and the bank adds that count, or a single tick for cycle events, to each counter whose event is currently selected. Counter 5 always tracks completed instructions and counter 6 always tracks clock cycles. Counters 1 to 4 take their event from an 8-bit selector. Some selector codes are valid on only one counter, and one code on counter 4 counts instructions only while the core's run-latch input is high.

Two control registers govern the bank. The mode register holds three freeze bits that cover different groups of counters, two overflow-enable bits, and an event-branch enable that gates the interrupt request. The selector register holds the four event selectors. When a counter with its overflow enable set reaches the negative threshold 0x80000000, it saturates there and raises an overflow event. Software reaches every register through a write port and an address-selected combinational read port.

Top module: `perf_counter_bank`

## Requirements
- R1: Synchronous active-high reset clears the mode register, the selector register and all six counters to zero, and drops `ovf_irq`.
- R2: Address 0 is the 32-bit mode register (the write keeps `wr_data[31:0]`), address 1 is the 64-bit selector register, and addresses 2 to 7 are counters 1 to 6 (the write keeps `wr_data[31:0]`). `rd_data` returns the addressed register zero-extended in the same cycle.
- R3: Mode bit 31 freezes all six counters. Mode bit 5 freezes counters 1 to 4 only. Mode bit 4 freezes counters 5 and 6 only.
- R4: Unless frozen, counter 5 counts completed instructions and counter 6 counts cycles, whatever the selector register holds.
- R5: The selector for counter n (n = 1 to 4) sits in selector register bits [39-8n : 32-8n]. On any of counters 1 to 4, code 0x02 counts completed instructions and code 0x1E counts cycles.
- R6: Code 0xF0 counts cycles and code 0xFE counts instructions on counter 1 only. On counters 2 to 4 these codes leave the counter idle, as does every code not listed in R5 to R7.
- R7: Code 0xFA on counter 4 counts completed instructions only in cycles where `run_latch` is high. On other counters it is idle.
- R8: An instruction-counting counter adds `insn_done` each cycle, which may exceed one. A cycle-counting counter adds one per clock.
- R9: Counter 1's overflow enable is mode bit 15, and counters 2 to 6 share mode bit 14. When a nonzero increment brings an enabled counter to 0x80000000 or above, the counter loads exactly 0x80000000. With the enable clear, the counter keeps adding and wraps modulo 2^32.
- R10: An overflow event occurs when an instruction increment clamps, or when a cycle increment first carries an enabled counter from below the threshold to the threshold. In the cycle after such an event, `ovf_irq` is high for one cycle if mode bit 20 is set. It stays low if bit 20 is clear.
- R11: A software write to a counter overrides any increment to that counter in the same clock, and that write raises no overflow event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 64 | Read data for `rd_addr`, zero-extended |
| insn_done | input | 4 | Number of instructions completed this cycle |
| run_latch | input | 1 | Core run-latch state, qualifies code 0xFA |
| ovf_irq | output | 1 | One-cycle overflow interrupt request |

## Verification
Two things can land in the same clock: a software write to a counter and an increment that the counter's live event would apply. The bench provokes this by writing counter 1 while it counts cycles. It then checks that the counter holds exactly the written value, not that value plus one, and that counting resumes from it on the next clock. A second same-cycle case is overflow detection together with the request gate. In one clock, an instruction increment drives a counter past the threshold. The bench checks the saturated value, and it checks that `ovf_irq` appears only when the event-branch bit is set and lasts a single cycle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int NUM_CNT  = 6;
    localparam int NUM_SEL  = 4;
    localparam int CNT_W    = 32;
    localparam int SEL_W    = 8;
    localparam int MODE_W   = 32;
    localparam int SELR_W   = 64;
    localparam int DATA_W   = 64;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_MODE     = 3'd0;
    localparam logic [ADDR_W-1:0] A_SELR     = 3'd1;
    localparam int                A_CNT_BASE = 2;

    localparam int B_FRZ_ALL = 31;
    localparam int B_EBB     = 20;
    localparam int B_OVE_1   = 15;
    localparam int B_OVE_N   = 14;
    localparam int B_FRZ_LO  = 5;
    localparam int B_FRZ_HI  = 4;

    localparam logic [CNT_W:0] THRESH = {2'b01, {(CNT_W-1){1'b0}}};

    typedef enum logic [1:0] {
        EV_NONE    = 2'd0,
        EV_INSN    = 2'd1,
        EV_CYC     = 2'd2,
        EV_INSN_RL = 2'd3
    } evt_e;

    function automatic evt_e decode_evt(input int unsigned idx,
                                        input logic [SEL_W-1:0] sel,
                                        input logic [MODE_W-1:0] mode);
        evt_e r;
        r = EV_NONE;
        if (mode[B_FRZ_ALL]) begin
            r = EV_NONE;
        end else if (idx < NUM_SEL) begin
            if (!mode[B_FRZ_LO]) begin
                case (sel)
                    8'h02:   r = EV_INSN;
                    8'h1E:   r = EV_CYC;
                    8'hF0:   r = (idx == 0) ? EV_CYC  : EV_NONE;
                    8'hFE:   r = (idx == 0) ? EV_INSN : EV_NONE;
                    8'hFA:   r = (idx == 3) ? EV_INSN_RL : EV_NONE;
                    default: r = EV_NONE;
                endcase
            end
        end else if (!mode[B_FRZ_HI]) begin
            r = (idx == NUM_SEL) ? EV_INSN : EV_CYC;
        end
        return r;
    endfunction

endpackage

// File: rtl/pmc_ctrl_regs.sv
module pmc_ctrl_regs
    import pmc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [MODE_W-1:0]   mode_q,
    output logic [SELR_W-1:0]   selr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            selr_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_MODE) mode_q <= wr_data[MODE_W-1:0];
            if (wr_addr == A_SELR) selr_q <= wr_data[SELR_W-1:0];
        end
    end

endmodule

// File: rtl/pmc_event_decode.sv
module pmc_event_decode
    import pmc_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [SELR_W-1:0] selr,
    output evt_e              ev     [NUM_CNT],
    output logic              ov_en  [NUM_CNT]
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_dec
        logic [SEL_W-1:0] sel;
        if (i < NUM_SEL) begin : g_sel
            assign sel = selr[(4*SEL_W - 1 - SEL_W*i) -: SEL_W];
        end else begin : g_fixed
            assign sel = '0;
        end
        assign ev[i]    = decode_evt(i, sel, mode);
        assign ov_en[i] = (i == 0) ? mode[B_OVE_1] : mode[B_OVE_N];
    end

endmodule

// File: rtl/pmc_counter.sv
module pmc_counter
    import pmc_pkg::*;
#(
    parameter int INSN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_e              ev,
    input  logic              ov_en,
    input  logic [INSN_W-1:0] insn_done,
    input  logic              run_latch,
    input  logic              wr_en,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              ovf_evt
);

    logic [CNT_W:0] step;
    logic [CNT_W:0] sum;
    logic           clamp;
    logic           below;

    always_comb begin
        step = '0;
        case (ev)
            EV_INSN:    step = {{(CNT_W+1-INSN_W){1'b0}}, insn_done};
            EV_CYC:     step = {{CNT_W{1'b0}}, 1'b1};
            EV_INSN_RL: step = run_latch ? {{(CNT_W+1-INSN_W){1'b0}}, insn_done} : '0;
            default:    step = '0;
        endcase
        sum     = {1'b0, cnt_q} + step;
        below   = ({1'b0, cnt_q} < THRESH);
        clamp   = ov_en && (step != '0) && (sum >= THRESH);
        ovf_evt = !wr_en && clamp && ((ev != EV_CYC) || below);
    end

    always_ff @(posedge clk) begin
        if (rst)        cnt_q <= '0;
        else if (wr_en) cnt_q <= wr_data;
        else if (clamp) cnt_q <= THRESH[CNT_W-1:0];
        else            cnt_q <= sum[CNT_W-1:0];
    end

    // R11
    wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> cnt_q == $past(wr_data));

    // R9
    clamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ov_en && !wr_en && ({1'b0, cnt_q} <= THRESH)) |=> ({1'b0, cnt_q} <= THRESH));

    // R3
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_NONE && !wr_en) |=> $stable(cnt_q));

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
    import pmc_pkg::*;
#(
    parameter int INSN_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [INSN_W-1:0] insn_done,
    input  logic              run_latch,
    output logic              ovf_irq
);

    logic [MODE_W-1:0] mode_q;
    logic [SELR_W-1:0] selr_q;
    evt_e              ev      [NUM_CNT];
    logic              ov_en   [NUM_CNT];
    logic [CNT_W-1:0]  cnt_val [NUM_CNT];
    logic [NUM_CNT-1:0] ovf_vec;

    pmc_ctrl_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .mode_q  (mode_q),
        .selr_q  (selr_q)
    );

    pmc_event_decode u_dec (
        .mode  (mode_q),
        .selr  (selr_q),
        .ev    (ev),
        .ov_en (ov_en)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic hit;
        assign hit = wr_en && (wr_addr == ADDR_W'(A_CNT_BASE + i));

        pmc_counter #(.INSN_W(INSN_W)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .ev        (ev[i]),
            .ov_en     (ov_en[i]),
            .insn_done (insn_done),
            .run_latch (run_latch),
            .wr_en     (hit),
            .wr_data   (wr_data[CNT_W-1:0]),
            .cnt_q     (cnt_val[i]),
            .ovf_evt   (ovf_vec[i])
        );

        // R3
        frz_all_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_q[B_FRZ_ALL] && !wr_en) |=> $stable(cnt_val[i]));
    end

    always_ff @(posedge clk) begin
        if (rst) ovf_irq <= 1'b0;
        else     ovf_irq <= (|ovf_vec) && mode_q[B_EBB];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_MODE)      rd_data = {{(DATA_W-MODE_W){1'b0}}, mode_q};
        else if (rd_addr == A_SELR) rd_data = selr_q;
        else begin
            for (int k = 0; k < NUM_CNT; k++)
                if (rd_addr == ADDR_W'(A_CNT_BASE + k))
                    rd_data = {{(DATA_W-CNT_W){1'b0}}, cnt_val[k]};
        end
    end

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_irq |-> $past(mode_q[B_EBB]));

    // R1
    rst_irq_chk: assert property (@(posedge clk)
        $past(rst) |-> !ovf_irq);

endmodule

// File: tb/perf_counter_bank_test.sv
module perf_counter_bank_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [63:0] rd_data;
    logic [3:0]  insn_done = '0;
    logic        run_latch = 1'b0;
    logic        ovf_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    localparam logic [63:0] FRZ_ALL = 64'h8000_0000;
    localparam logic [63:0] EBB     = 64'h0010_0000;
    localparam logic [63:0] OVE1    = 64'h0000_8000;
    localparam logic [63:0] OVEN    = 64'h0000_4000;
    localparam logic [63:0] FRZ_LO  = 64'h0000_0020;
    localparam logic [63:0] FRZ_HI  = 64'h0000_0010;

    always #10 clk = ~clk;

    perf_counter_bank uut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .insn_done (insn_done),
        .run_latch (run_latch),
        .ovf_irq   (ovf_irq)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk_cnt(input string tag, input int n, input logic [31:0] exp);
        logic [63:0] v;
        rd(3'(n + 1), v);
        chk(tag, v, {32'b0, exp});
    endtask

    task automatic setup(input logic [63:0] selr, input logic [31:0] c1, input logic [31:0] c2,
                         input logic [31:0] c3, input logic [31:0] c4, input logic [31:0] c5,
                         input logic [31:0] c6);
        wr(3'd0, FRZ_ALL);
        wr(3'd1, selr);
        wr(3'd2, {32'b0, c1}); wr(3'd3, {32'b0, c2}); wr(3'd4, {32'b0, c3});
        wr(3'd5, {32'b0, c4}); wr(3'd6, {32'b0, c5}); wr(3'd7, {32'b0, c6});
    endtask

    task automatic run(input int n, input logic [3:0] ins, input logic rl);
        insn_done = ins; run_latch = rl;
        repeat (n) @(negedge clk);
        insn_done = '0; run_latch = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset value", v, 64'd0);
        end
        chk("R1 reset irq", {63'b0, ovf_irq}, 64'd0);
    endtask

    task automatic t_regs();
        logic [63:0] v;
        wr(3'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(3'd0, v); chk("R2 mode width", v, 64'h0000_0000_FFFF_FFFF);
        wr(3'd1, 64'hA5A5_5A5A_0123_4567);
        rd(3'd1, v); chk("R2 selector readback", v, 64'hA5A5_5A5A_0123_4567);
        wr(3'd4, 64'hDEAD_BEEF_CAFE_F00D);
        rd(3'd4, v); chk("R2 counter width", v, 64'h0000_0000_CAFE_F00D);
    endtask

    task automatic t_freeze();
        setup(64'h1E00_0000, 0, 0, 0, 0, 0, 0);
        wr(3'd0, FRZ_LO);
        run(3, 4'd0, 1'b0);
        chk_cnt("R3 lo freeze c1", 1, 32'd0);
        chk_cnt("R3 lo freeze c6 runs", 6, 32'd3);
        setup(64'h1E00_0000, 0, 0, 0, 0, 0, 0);
        wr(3'd0, FRZ_HI);
        run(3, 4'd2, 1'b0);
        chk_cnt("R3 hi freeze c1 runs", 1, 32'd3);
        chk_cnt("R3 hi freeze c5", 5, 32'd0);
        chk_cnt("R3 hi freeze c6", 6, 32'd0);
        setup(64'h1E1E_1E1E, 7, 0, 0, 0, 0, 0);
        run(4, 4'd3, 1'b0);
        chk_cnt("R3 all freeze c1", 1, 32'd7);
        chk_cnt("R3 all freeze c5", 5, 32'd0);
        chk_cnt("R3 all freeze c6", 6, 32'd0);
    endtask

    task automatic t_fixed();
        setup(64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 0, 0, 0);
        wr(3'd0, 64'd0);
        run(4, 4'd3, 1'b0);
        chk_cnt("R4 c5 instructions", 5, 32'd12);
        chk_cnt("R4 c6 cycles", 6, 32'd4);
        chk_cnt("R6 unknown code c1 idle", 1, 32'd0);
    endtask

    task automatic t_sel_a();
        setup({32'b0, 8'h02, 8'h1E, 8'hF0, 8'hFE}, 0, 0, 0, 0, 0, 0);
        wr(3'd0, 64'd0);
        run(5, 4'd2, 1'b0);
        chk_cnt("R5 c1 code02", 1, 32'd10);
        chk_cnt("R5 c2 code1E", 2, 32'd5);
        chk_cnt("R6 c3 codeF0 idle", 3, 32'd0);
        chk_cnt("R6 c4 codeFE idle", 4, 32'd0);
        chk_cnt("R8 c5 multi insn", 5, 32'd10);
    endtask

    task automatic t_sel_b();
        setup({32'b0, 8'hF0, 8'h55, 8'h02, 8'h1E}, 0, 0, 0, 0, 0, 0);
        wr(3'd0, 64'd0);
        run(4, 4'd7, 1'b0);
        chk_cnt("R6 c1 codeF0 cycles", 1, 32'd4);
        chk_cnt("R6 c2 code55 idle", 2, 32'd0);
        chk_cnt("R8 c3 adds 7 per cycle", 3, 32'd28);
        chk_cnt("R5 c4 code1E", 4, 32'd4);
    endtask

    task automatic t_runlatch();
        setup({32'b0, 8'hFE, 8'hFA, 8'h1E, 8'hFA}, 0, 0, 0, 0, 0, 0);
        wr(3'd0, 64'd0);
        run(3, 4'd5, 1'b1);
        chk_cnt("R6 c1 codeFE insn", 1, 32'd15);
        chk_cnt("R7 c2 codeFA idle", 2, 32'd0);
        chk_cnt("R7 c4 latch high", 4, 32'd15);
        run(2, 4'd5, 1'b0);
        chk_cnt("R7 c4 latch low", 4, 32'd15);
        chk_cnt("R6 c1 keeps counting", 1, 32'd25);
    endtask

    task automatic t_clamp();
        setup({32'b0, 8'h02, 8'h02, 8'h00, 8'h00}, 32'h7FFF_FFFE, 32'h7FFF_FFFF, 0, 0, 0, 0);
        wr(3'd0, OVE1 | FRZ_HI);
        run(1, 4'd3, 1'b0);
        chk_cnt("R9 c1 clamps", 1, 32'h8000_0000);
        chk_cnt("R9 c2 no enable adds", 2, 32'h8000_0002);
        chk("R10 no irq without ebb", {63'b0, ovf_irq}, 64'd0);
        setup({32'b0, 8'h00, 8'h00, 8'h00, 8'h02}, 0, 0, 0, 32'hFFFF_FFFE, 0, 0);
        wr(3'd0, FRZ_HI);
        run(1, 4'd3, 1'b0);
        chk_cnt("R9 c4 wraps", 4, 32'h0000_0001);
    endtask

    task automatic t_irq_insn();
        setup({32'b0, 8'h00, 8'h00, 8'h02, 8'h00}, 0, 0, 32'h7FFF_FFFD, 0, 0, 0);
        wr(3'd0, OVEN | EBB | FRZ_HI);
        run(1, 4'd2, 1'b0);
        chk("R10 no irq below", {63'b0, ovf_irq}, 64'd0);
        chk_cnt("R8 c3 below", 3, 32'h7FFF_FFFF);
        run(1, 4'd2, 1'b0);
        chk("R10 irq on clamp", {63'b0, ovf_irq}, 64'd1);
        chk_cnt("R9 c3 clamped", 3, 32'h8000_0000);
        run(1, 4'd0, 1'b0);
        chk("R10 irq one cycle", {63'b0, ovf_irq}, 64'd0);
    endtask

    task automatic t_irq_cyc();
        setup(64'd0, 0, 0, 0, 0, 0, 32'h7FFF_FFFE);
        wr(3'd0, OVEN | EBB | FRZ_LO);
        run(1, 4'd0, 1'b0);
        chk("R10 cyc below", {63'b0, ovf_irq}, 64'd0);
        run(1, 4'd0, 1'b0);
        chk("R10 cyc crossing irq", {63'b0, ovf_irq}, 64'd1);
        chk_cnt("R9 c6 at threshold", 6, 32'h8000_0000);
        run(1, 4'd0, 1'b0);
        chk("R10 cyc no repeat", {63'b0, ovf_irq}, 64'd0);
        chk_cnt("R9 c6 held", 6, 32'h8000_0000);
    endtask

    task automatic t_wr_prio();
        setup(64'h1E00_0000, 0, 0, 0, 0, 0, 0);
        wr(3'd0, FRZ_HI);
        run(2, 4'd0, 1'b0);
        wr(3'd2, 64'h1234);
        chk_cnt("R11 write beats increment", 1, 32'h1234);
        run(1, 4'd0, 1'b0);
        chk_cnt("R11 counting resumes", 1, 32'h1235);
        setup({32'b0, 8'h02, 8'h00, 8'h00, 8'h00}, 32'h7FFF_FFFF, 0, 0, 0, 0, 0);
        wr(3'd0, OVE1 | EBB | FRZ_HI);
        insn_done = 4'd4;
        wr(3'd2, 64'h10);
        insn_done = 4'd0;
        chk_cnt("R11 write over clamp", 1, 32'h10);
        chk("R11 write raises no irq", {63'b0, ovf_irq}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_freeze();
        t_fixed();
        t_sel_a();
        t_sel_b();
        t_runlatch();
        t_clamp();
        t_irq_insn();
        t_irq_cyc();
        t_wr_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule